// File: doc/BRIEF.md
# Addressed Two-Frame Byte Latch

This block sits behind a serial frame receiver on a line that several devices share. Each decoded frame it receives carries a 3-bit device address, a 4-bit nibble and a one-cycle valid strobe. Two consecutive frames form one byte. The first frame carries the low nibble and the second carries the high nibble. The block acts only on frames whose address matches its three strap inputs. When both halves of a pair carry the same address, the byte is latched and held on eight parallel outputs. A one-cycle acknowledge pulse is raised whenever the held value actually changes.

The block also models the output pins as a value and an output-enable per pin. In push-pull mode each pin drives the held bit. In open-collector mode a held 1 pulls the pin low and a held 0 releases it; an external pull-up makes a released pin read high. An output-disable input and the active-low reset override the held data. A disabled pin goes high-impedance in push-pull mode and is released in open-collector mode. While reset is held, push-pull pins drive low and open-collector pins are released.

Top module: `nibble_pair_latch`

## Requirements
- R1: After reset, with outputs enabled, the held byte is 0x00 and `ack` is 0. In push-pull mode this gives `pin_oe`=0xFF and `pin_o`=0x00. In open-collector mode it gives `pin_oe`=0x00.
- R2: A strap-matching frame with no half pending supplies bits 3:0. The next frame, if it has the same address, supplies bits 7:4. The new byte appears on the pins in the cycle after the second strobe is sampled. In that same cycle `ack` is 1, and it is 0 in the cycle after.
- R3: A frame whose address differs from the strap inputs, arriving while no half is pending, is ignored. The pins stay unchanged, `ack` stays 0, and the next two matching frames still form a byte.
- R4: If the frame after a pending first half carries a different address, the pair is dropped. The pins stay unchanged, `ack` stays 0, and the next matching frame starts a new pair.
- R5: A completed pair whose byte equals the held byte produces no `ack` pulse and leaves the pins unchanged.
- R6: In open-collector mode (`pp_sel`=0, `out_dis`=0, `rst_n`=1), `pin_oe[i]` equals held bit i and `pin_o` is 0x00. A held 1 therefore pulls its pin low.
- R7: In push-pull mode (`pp_sel`=1, `out_dis`=0, `rst_n`=1), `pin_oe` is 0xFF and `pin_o` equals the held byte.
- R8: With `out_dis`=1, `pin_oe` is 0x00 and `pin_o` is 0x00 in both modes. Push-pull pins are then high-impedance and open-collector pins are released.
- R9: While `rst_n` is 0 with outputs enabled, the pins follow reset in the same cycle, even before the reset edge. Push-pull gives `pin_oe`=0xFF and `pin_o`=0x00; open-collector gives `pin_oe`=0x00.
- R10: Reset discards a pending first half, so the first matching frame after reset is a new low nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also forces the pin reset levels |
| strap_addr | input | 3 | Device address straps |
| frm_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| frm_addr | input | 3 | Address field of the frame |
| frm_nib | input | 4 | Nibble field of the frame |
| pp_sel | input | 1 | 1 = push-pull pins, 0 = open-collector pins |
| out_dis | input | 1 | 1 = all pins off (high-impedance or released) |
| pin_o | output | 8 | Driven level per pin, 0 when its enable is off |
| pin_oe | output | 8 | Output enable per pin |
| ack | output | 1 | One-cycle pulse when the held byte changes |

## Verification
Frame-driven results have one register stage of latency. The held byte and `ack` are due in the cycle after the clock edge that samples the second strobe, and `ack` must be low again one cycle later. Pin mode, disable and reset levels are combinational and are due in the same cycle as the input change. Each frame is driven on a falling edge and held for one rising edge. The bench checks at the next falling edge, which lands inside the window where the pulse and the new byte must be visible. Mode and reset changes are checked at a point half a cycle before any rising edge. This separates the pin levels that reset forces combinationally from the clearing of the register.

// File: rtl/nibble_latch_pkg.sv
// Package: shared sizes and the pairing phase type for the byte latch.
// Assumes one address field and two equal nibbles per byte.
package nibble_latch_pkg;
    localparam int ADDR_W = 3;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    typedef enum logic {
        PHASE_LOW  = 1'b0,
        PHASE_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/nl_frame_pairer.sv
// Module: pairs decoded frames into bytes.
// What it does: a strap-matching frame with no half pending is kept as the
// low nibble. The next frame of any address closes the pair. The pair
// completes only when that frame's address equals the kept one; otherwise
// it is dropped.
// Assumes: frm_valid is high for one cycle per frame.
module nl_frame_pairer
    import nibble_latch_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int N_W = NIB_W,
    localparam int B_W = 2 * N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] strap_addr,
    input  logic           frm_valid,
    input  logic [A_W-1:0] frm_addr,
    input  logic [N_W-1:0] frm_nib,
    output logic           byte_stb,
    output logic [B_W-1:0] byte_val
);
    phase_t         phase_q;
    logic [A_W-1:0] pend_addr_q;
    logic [N_W-1:0] pend_nib_q;
    logic           take_first;
    logic           close_pair;

    // Classify the incoming frame against the pairing phase.
    always_comb begin
        take_first = frm_valid && (phase_q == PHASE_LOW) && (frm_addr == strap_addr);
        close_pair = frm_valid && (phase_q == PHASE_HIGH);
        byte_stb   = close_pair && (frm_addr == pend_addr_q);
        byte_val   = {frm_nib, pend_nib_q};
    end

    // Track the pending low half and the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PHASE_LOW;
            pend_addr_q <= '0;
            pend_nib_q  <= '0;
        end else if (take_first) begin
            phase_q     <= PHASE_HIGH;
            pend_addr_q <= frm_addr;
            pend_nib_q  <= frm_nib;
        end else if (close_pair) begin
            phase_q     <= PHASE_LOW;
        end
    end

    // R3: a foreign frame never completes a byte.
    p_no_foreign_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && (frm_addr != strap_addr)) |-> !byte_stb);

    // R4: a completed byte always follows a kept half with the same address.
    p_pair_same_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |-> (pend_addr_q == strap_addr));
endmodule

// File: rtl/nl_data_reg.sv
// Module: holds the latched byte and raises the change acknowledge.
// What it does: loads a completed byte and pulses ack for one cycle when
// the loaded value differs from the held one.
// Assumes: byte_stb never comes on two consecutive cycles (two frames per byte).
module nl_data_reg #(
    parameter int B_W = nibble_latch_pkg::BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           byte_stb,
    input  logic [B_W-1:0] byte_val,
    output logic [B_W-1:0] held,
    output logic           ack
);
    // Load a new byte and flag a real change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            ack  <= 1'b0;
        end else begin
            ack <= byte_stb && (byte_val != held);
            if (byte_stb) begin
                held <= byte_val;
            end
        end
    end

    // R2: the acknowledge is a single-cycle pulse.
    p_ack_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    // R5: an acknowledge only accompanies a changed byte.
    p_ack_on_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (held != $past(held)));

    // R4: with no completed pair the held byte stays put.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_stb |=> $stable(held));
endmodule

// File: rtl/nl_pad_bank.sv
// Module: per-pin output model.
// What it does: turns each held bit into a pin level and an output enable
// for push-pull or open-collector mode, with disable and reset overrides.
// Assumes: a released open-collector pin is pulled high outside the block.
module nl_pad_bank #(
    parameter int B_W = nibble_latch_pkg::BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pp_sel,
    input  logic           out_dis,
    input  logic [B_W-1:0] held,
    output logic [B_W-1:0] pin_o,
    output logic [B_W-1:0] pin_oe
);
    logic drive_pp;
    logic drive_oc;

    // Shared mode decode for all pins.
    always_comb begin
        drive_pp = pp_sel && !out_dis;
        drive_oc = !pp_sel && !out_dis && rst_n;
    end

    for (genvar i = 0; i < B_W; i++) begin : g_pin
        // One pin: enable and level from mode, reset and held bit.
        always_comb begin
            pin_oe[i] = drive_pp || (drive_oc && held[i]);
            pin_o[i]  = drive_pp && rst_n && held[i];
        end
    end

    // R6: an open-collector pin never drives high.
    p_oc_no_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !pp_sel |-> (pin_o == '0));

    // R8: disabled pins are all off.
    p_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_dis |-> (pin_oe == '0));

    // R9: during reset no pin drives high.
    p_reset_low_r9: assert property (@(posedge clk)
        !rst_n |-> (pin_o == '0));
endmodule

// File: rtl/nibble_pair_latch.sv
// Module: top of the addressed two-frame byte latch.
// What it does: chains the frame pairer, the data register and the pin bank.
// Assumes: frames arrive already decoded, one strobe each.
module nibble_pair_latch
    import nibble_latch_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int N_W = NIB_W,
    localparam int B_W = 2 * N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [A_W-1:0] strap_addr,
    input  logic           frm_valid,
    input  logic [A_W-1:0] frm_addr,
    input  logic [N_W-1:0] frm_nib,
    input  logic           pp_sel,
    input  logic           out_dis,
    output logic [B_W-1:0] pin_o,
    output logic [B_W-1:0] pin_oe,
    output logic           ack
);
    logic           byte_stb;
    logic [B_W-1:0] byte_val;
    logic [B_W-1:0] held;

    nl_frame_pairer #(.A_W(A_W), .N_W(N_W)) u_pairer (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_nib(frm_nib),
        .byte_stb(byte_stb), .byte_val(byte_val)
    );

    nl_data_reg #(.B_W(B_W)) u_data (
        .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
        .held(held), .ack(ack)
    );

    nl_pad_bank #(.B_W(B_W)) u_pads (
        .clk(clk), .rst_n(rst_n), .pp_sel(pp_sel), .out_dis(out_dis),
        .held(held), .pin_o(pin_o), .pin_oe(pin_oe)
    );
endmodule

// File: tb/nibble_pair_latch_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module nibble_pair_latch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap_addr = 3'd5;
    logic       frm_valid = 1'b0;
    logic [2:0] frm_addr = '0;
    logic [3:0] frm_nib = '0;
    logic       pp_sel = 1'b1;
    logic       out_dis = 1'b0;
    logic [7:0] pin_o;
    logic [7:0] pin_oe;
    logic       ack;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    nibble_pair_latch u_nibble_pair_latch (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
        .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_nib(frm_nib),
        .pp_sel(pp_sel), .out_dis(out_dis),
        .pin_o(pin_o), .pin_oe(pin_oe), .ack(ack)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected pins for the held byte under the current mode, disable and reset.
    task automatic chk_pins(input string tag, input logic [7:0] held);
        logic [7:0] eo, eoe;
        if (out_dis) begin
            eoe = 8'h00; eo = 8'h00;
        end else if (pp_sel) begin
            eoe = 8'hFF; eo = rst_n ? held : 8'h00;
        end else begin
            eoe = rst_n ? held : 8'h00; eo = 8'h00;
        end
        chk({tag, " oe"}, pin_oe, eoe);
        chk({tag, " o"},  pin_o,  eo);
    endtask

    // Drive one frame for one rising edge; returns at the following falling edge.
    task automatic send(input logic [2:0] a, input logic [3:0] n);
        @(negedge clk);
        frm_valid = 1'b1; frm_addr = a; frm_nib = n;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        pp_sel = 1'b1;
        chk_pins("R1 pp", 8'h00);
        chk("R1 ack", {7'b0, ack}, 8'h00);
        pp_sel = 1'b0;
        #1 chk_pins("R1 oc", 8'h00);
        pp_sel = 1'b1;
    endtask

    task automatic t_pair();
        send(3'd5, 4'h3);
        chk("R2 after first", {7'b0, ack}, 8'h00);
        chk_pins("R2 first unchanged", 8'h00);
        send(3'd5, 4'hA);
        chk_pins("R2 byte", 8'hA3);
        chk("R2 ack", {7'b0, ack}, 8'h01);
        @(negedge clk);
        chk("R2 ack drop", {7'b0, ack}, 8'h00);
    endtask

    task automatic t_modes();
        pp_sel = 1'b0;
        #1 chk_pins("R6 oc", 8'hA3);
        pp_sel = 1'b1;
        #1 chk_pins("R7 pp", 8'hA3);
        out_dis = 1'b1;
        #1 chk_pins("R8 pp off", 8'hA3);
        pp_sel = 1'b0;
        #1 chk_pins("R8 oc off", 8'hA3);
        out_dis = 1'b0; pp_sel = 1'b1;
    endtask

    task automatic t_foreign();
        send(3'd2, 4'hE);
        chk_pins("R3 ignored", 8'hA3);
        chk("R3 no ack", {7'b0, ack}, 8'h00);
        send(3'd5, 4'h1);
        send(3'd5, 4'h7);
        chk_pins("R3 next pair", 8'h71);
        chk("R3 ack", {7'b0, ack}, 8'h01);
    endtask

    task automatic t_mismatch();
        send(3'd5, 4'hC);
        send(3'd3, 4'hE);
        chk_pins("R4 dropped", 8'h71);
        chk("R4 no ack", {7'b0, ack}, 8'h00);
        send(3'd5, 4'h4);
        send(3'd5, 4'h2);
        chk_pins("R4 new pair", 8'h24);
        chk("R4 ack", {7'b0, ack}, 8'h01);
    endtask

    task automatic t_same_value();
        send(3'd5, 4'h4);
        send(3'd5, 4'h2);
        chk_pins("R5 same", 8'h24);
        chk("R5 no ack", {7'b0, ack}, 8'h00);
    endtask

    task automatic t_reset_override();
        send(3'd5, 4'h5);
        send(3'd5, 4'hA);
        chk_pins("R9 loaded", 8'hA5);
        rst_n = 1'b0;
        #1 chk_pins("R9 pp in reset", 8'hA5);
        pp_sel = 1'b0;
        #1 chk_pins("R9 oc in reset", 8'hA5);
        pp_sel = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        #1 chk_pins("R1 cleared", 8'h00);
    endtask

    task automatic t_reset_pending();
        send(3'd5, 4'hF);
        do_reset();
        send(3'd5, 4'h6);
        chk_pins("R10 first half", 8'h00);
        send(3'd5, 4'h9);
        chk_pins("R10 new pair", 8'h96);
    endtask

    initial begin
        t_reset_state();
        t_pair();
        t_modes();
        t_foreign();
        t_mismatch();
        t_same_value();
        t_reset_override();
        t_reset_pending();
        done = 1'b1;
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule